// File: doc/BRIEF.md
# Contact Smart Card Power-Up Sequencer

This controller brings a contact smart card from an unpowered slot to a running session when the host asks for one. It counts periods of an internal oscillator, which arrive as single-cycle pulses on `osc_tick`. It grants the card supply, releases the data lines, and gates the card clock on. Finally it connects the card reset line to the host, with every step placed at a fixed number of oscillator periods after the supply reports ready.

The unit of the timeline is one sequence period of `TICKS_PER_T` oscillator ticks, counted internally in half periods. The host decides how the card clock starts through the level of its reset line at the moment it requests a session. A low level lets the clock start together with the data lines. A high level holds the clock back until the host drops its reset line, so the host can count clock edges exactly before the card reset is released. Dropping the request, or losing the card, ends the session at once.

Top module: `card_act_seq`

## Requirements
- R1: With `sess_cmd_n` high and no card present after reset, `osc_fast`, `supply_en`, `ramp_done`, `io_en`, `clk_gate` and `card_rst` are all low.
- R2: While `sess_cmd_n` is high, `present_flag` equals `card_present` combinationally: 1 for a card in the slot, 0 for an empty slot.
- R3: `osc_fast` is high in the same cycle in which `sess_cmd_n` is low and `card_present` is high. `supply_en` follows one clock edge later.
- R4: `ramp_done` stays low until `supply_ready` has been sampled high in the waiting state. It rises once 3 half periods (1.5 sequence periods) of ticks have been counted after that edge.
- R5: `io_en` rises once 8 half periods (4 sequence periods) have been counted, and is never high without `ramp_done`.
- R6: `card_rst` is low until 14 half periods (7 sequence periods) have been counted. From then on it equals `host_rst` combinationally.
- R7: If `host_rst` is low on the edge that starts the session, `clk_gate` rises together with `io_en`.
- R8: If `host_rst` is high on the starting edge, `clk_gate` stays low at the 4-period point. It rises on the edge after `host_rst` is first sampled low between the 4-period and 7-period points.
- R9: In the delayed case, `clk_gate` rises at the 7-period point if `host_rst` is still high. Once the clock is on, later changes of `host_rst` do not turn it off.
- R10: `sess_cmd_n` high or `card_present` low forces all sequence outputs low in the same cycle. The next session counts again from zero.
- R11: Only cycles with `osc_tick` high advance the timeline. With a tick every second cycle, every point moves to about twice as many clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| osc_tick | input | 1 | One pulse per internal oscillator period |
| card_present | input | 1 | High while a card sits in the slot |
| sess_cmd_n | input | 1 | Host session request, active low |
| host_rst | input | 1 | Host-side reset level for the card |
| supply_ready | input | 1 | Card supply generator reports ready |
| osc_fast | output | 1 | Requests the high oscillator frequency |
| supply_en | output | 1 | Enables the card supply generator |
| ramp_done | output | 1 | Supply ramp period has elapsed |
| io_en | output | 1 | Releases the I/O and auxiliary lines |
| clk_gate | output | 1 | Lets the clock through to the card |
| card_rst | output | 1 | Reset line driven to the card |
| present_flag | output | 1 | Card presence status for the host |

## Verification
The properties assume that every input is synchronous to `clk` and changes only between edges. They also assume that `supply_ready` is not raised before a session has started. The hold property on the card clock relies on the host keeping `sess_cmd_n` and `card_present` steady except when it deliberately aborts. The stimulus drives all inputs a quarter period after an edge. It generates `osc_tick` at the falling clock edge, and it clears `supply_ready` before every new request, so these assumptions hold throughout.

// File: rtl/card_act_pkg.sv
package card_act_pkg;

    // Sequence states
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_SUP = 2'd1,
        ST_RUN      = 2'd2
    } seq_state_e;

    // Timeline points in half sequence periods after supply ready
    localparam int unsigned HALF_RAMP = 3;
    localparam int unsigned HALF_IO   = 8;
    localparam int unsigned HALF_RST  = 14;
    localparam int unsigned HCNT_W    = $clog2(HALF_RST + 1);

endpackage

// File: rtl/card_act_tick_cnt.sv
module card_act_tick_cnt
    import card_act_pkg::*;
#(
    parameter int unsigned HALF_TICKS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    output logic [HCNT_W-1:0] half_cnt
);
    localparam int unsigned SUB_W = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [SUB_W-1:0]  SUB_LAST = SUB_W'(HALF_TICKS - 1);
    localparam logic [HCNT_W-1:0] HALF_SAT = HCNT_W'(HALF_RST);

    typedef struct packed {
        logic [SUB_W-1:0]  sub;
        logic [HCNT_W-1:0] half;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (en && tick) begin
            if (cnt_q.sub == SUB_LAST) begin
                cnt_d.sub = '0;
                if (cnt_q.half != HALF_SAT) begin
                    cnt_d.half = cnt_q.half + 1'b1;
                end
            end else begin
                cnt_d.sub = cnt_q.sub + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign half_cnt = cnt_q.half;

endmodule

// File: rtl/card_act_fsm.sv
module card_act_fsm
    import card_act_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sess_ok,
    input  logic       supply_ready,
    input  logic       host_rst,
    output seq_state_e state,
    output logic       late_clk
);
    typedef struct packed {
        seq_state_e st;
        logic       late;
    } fsm_t;

    fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d = fsm_q;
        if (!sess_ok) begin
            fsm_d.st   = ST_IDLE;
            fsm_d.late = 1'b0;
        end else begin
            unique case (fsm_q.st)
                ST_IDLE: begin
                    fsm_d.st   = ST_WAIT_SUP;
                    fsm_d.late = host_rst;   // clock start mode fixed here
                end
                ST_WAIT_SUP: begin
                    if (supply_ready) begin
                        fsm_d.st = ST_RUN;
                    end
                end
                ST_RUN: begin
                    fsm_d.st = ST_RUN;
                end
                default: begin
                    fsm_d.st = ST_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q <= '{st: ST_IDLE, late: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state    = fsm_q.st;
    assign late_clk = fsm_q.late;

endmodule

// File: rtl/card_act_out.sv
module card_act_out
    import card_act_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sess_ok,
    input  seq_state_e        state,
    input  logic              late_clk,
    input  logic [HCNT_W-1:0] half_cnt,
    input  logic              host_rst,
    output logic              supply_en,
    output logic              ramp_done,
    output logic              io_en,
    output logic              clk_gate,
    output logic              card_rst
);
    typedef struct packed {
        logic clk_on;
    } out_t;

    out_t out_d, out_q;
    logic run, at_ramp, at_io, at_rst;

    assign run     = sess_ok && (state == ST_RUN);
    assign at_ramp = half_cnt >= HCNT_W'(HALF_RAMP);
    assign at_io   = half_cnt >= HCNT_W'(HALF_IO);
    assign at_rst  = half_cnt >= HCNT_W'(HALF_RST);

    always_comb begin
        out_d = out_q;
        if (!run) begin
            out_d.clk_on = 1'b0;
        end else if (late_clk && at_io && !at_rst && !host_rst) begin
            out_d.clk_on = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign supply_en = sess_ok && (state != ST_IDLE);
    assign ramp_done = run && at_ramp;
    assign io_en     = run && at_io;
    assign clk_gate  = run && ((at_io && !late_clk) || at_rst || out_q.clk_on);
    assign card_rst  = run && at_rst && host_rst;

endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
    import card_act_pkg::*;
#(
    parameter int unsigned TICKS_PER_T = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic card_present,
    input  logic sess_cmd_n,
    input  logic host_rst,
    input  logic supply_ready,
    output logic osc_fast,
    output logic supply_en,
    output logic ramp_done,
    output logic io_en,
    output logic clk_gate,
    output logic card_rst,
    output logic present_flag
);
    localparam int unsigned HALF_TICKS = (TICKS_PER_T >= 2) ? TICKS_PER_T / 2 : 1;

    logic              sess_ok;
    seq_state_e        state;
    logic              late_clk;
    logic [HCNT_W-1:0] half_cnt;

    assign sess_ok      = !sess_cmd_n && card_present;
    assign osc_fast     = sess_ok;
    assign present_flag = card_present;

    card_act_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sess_ok      (sess_ok),
        .supply_ready (supply_ready),
        .host_rst     (host_rst),
        .state        (state),
        .late_clk     (late_clk)
    );

    card_act_tick_cnt #(
        .HALF_TICKS (HALF_TICKS)
    ) i_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state != ST_RUN),
        .en       (sess_ok),
        .tick     (osc_tick),
        .half_cnt (half_cnt)
    );

    card_act_out i_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .sess_ok   (sess_ok),
        .state     (state),
        .late_clk  (late_clk),
        .half_cnt  (half_cnt),
        .host_rst  (host_rst),
        .supply_en (supply_en),
        .ramp_done (ramp_done),
        .io_en     (io_en),
        .clk_gate  (clk_gate),
        .card_rst  (card_rst)
    );

endmodule

// File: rtl/card_act_chk.sv
module card_act_chk (
    input logic clk,
    input logic rst_n,
    input logic card_present,
    input logic sess_cmd_n,
    input logic host_rst,
    input logic osc_fast,
    input logic supply_en,
    input logic ramp_done,
    input logic io_en,
    input logic clk_gate,
    input logic card_rst,
    input logic present_flag
);
    logic ended;
    assign ended = sess_cmd_n || !card_present;

    p_abort_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ended |-> !(osc_fast || supply_en || ramp_done || io_en || clk_gate || card_rst));

    p_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sess_cmd_n |-> (present_flag == card_present));

    p_fast_osc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !ended |-> osc_fast);

    p_ramp_supply_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ramp_done) |-> $past(supply_en));

    p_io_after_ramp_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_en |-> ramp_done);

    p_rst_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        card_rst |-> (host_rst && io_en));

    p_clk_needs_io_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate |-> io_en);

    p_clk_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_gate && !ended) |=> (clk_gate || sess_cmd_n || !card_present));

endmodule

bind card_act_seq card_act_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .card_present (card_present),
    .sess_cmd_n   (sess_cmd_n),
    .host_rst     (host_rst),
    .osc_fast     (osc_fast),
    .supply_en    (supply_en),
    .ramp_done    (ramp_done),
    .io_en        (io_en),
    .clk_gate     (clk_gate),
    .card_rst     (card_rst),
    .present_flag (present_flag)
);

// File: tb/test_card_act_seq.sv
module test_card_act_seq;
    localparam int CLK_PER = 10;
    localparam int Q       = CLK_PER / 4;

    logic clk = 1'b0;
    logic rst_n, osc_tick, card_present, sess_cmd_n, host_rst, supply_ready;
    logic osc_fast, supply_en, ramp_done, io_en, clk_gate, card_rst, present_flag;
    logic tick_half = 1'b0;

    int n_chk = 0;
    int n_err = 0;
    int cur   = 0;

    // {sess_cmd_n, card_present, expected present_flag, expected osc_fast}
    localparam logic [3:0] VEC [4] = '{4'b1000, 4'b1110, 4'b0000, 4'b0111};

    card_act_seq i_card_act_seq (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .card_present(card_present),
        .sess_cmd_n(sess_cmd_n), .host_rst(host_rst), .supply_ready(supply_ready),
        .osc_fast(osc_fast), .supply_en(supply_en), .ramp_done(ramp_done),
        .io_en(io_en), .clk_gate(clk_gate), .card_rst(card_rst),
        .present_flag(present_flag)
    );

    always #(CLK_PER/2) clk = ~clk;

    initial begin
        osc_tick = 1'b1;
        forever begin
            @(negedge clk);
            osc_tick = tick_half ? ~osc_tick : 1'b1;
        end
    end

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic all_low(input string req);
        chk(req, osc_fast | supply_en | ramp_done | io_en | clk_gate | card_rst, 1'b0);
    endtask

    task automatic adv_to(input int k);
        repeat (k - cur) @(posedge clk);
        cur = k;
        #(Q);
    endtask

    task automatic begin_session(input logic hr);
        host_rst = hr; card_present = 1'b1; sess_cmd_n = 1'b0;
        #1;
        chk("R3 osc_fast same cycle", osc_fast, 1'b1);
        chk("R3 supply_en not yet", supply_en, 1'b0);
        @(posedge clk); #(Q);
        chk("R3 supply_en after edge", supply_en, 1'b1);
        repeat (3) @(posedge clk); #(Q);
        chk("R4 no ramp before supply ready", ramp_done, 1'b0);
        supply_ready = 1'b1;
        @(posedge clk);
        cur = 0;
        #(Q);
    endtask

    task automatic end_session();
        sess_cmd_n = 1'b1;
        #1;
        all_low("R10 command release");
        supply_ready = 1'b0;
        @(posedge clk); #(Q);
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_err++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        rst_n = 1'b0; card_present = 1'b0; sess_cmd_n = 1'b1;
        host_rst = 1'b0; supply_ready = 1'b0;
        repeat (3) @(posedge clk); #(Q);
        all_low("R1 during reset");
        rst_n = 1'b1;
        @(posedge clk); #(Q);
        all_low("R1 after reset");

        // R2 / R3 table walk, restored before each edge
        foreach (VEC[i]) begin
            sess_cmd_n = VEC[i][3]; card_present = VEC[i][2];
            #1;
            chk("R2 presence flag", present_flag, VEC[i][1]);
            chk("R3 oscillator select", osc_fast, VEC[i][0]);
            sess_cmd_n = 1'b1; card_present = 1'b0;
            @(posedge clk); #(Q);
        end

        // Immediate clock (R4 R5 R6 R7)
        begin_session(1'b0);
        adv_to(95);  chk("R4 ramp before 1.5T", ramp_done, 1'b0);
        adv_to(96);  chk("R4 ramp at 1.5T", ramp_done, 1'b1);
        adv_to(255); chk("R5 io before 4T", io_en, 1'b0);
                     chk("R7 clk before 4T", clk_gate, 1'b0);
        adv_to(256); chk("R5 io at 4T", io_en, 1'b1);
                     chk("R7 clk with io", clk_gate, 1'b1);
        adv_to(300); host_rst = 1'b1;
        adv_to(447); chk("R6 reset held before 7T", card_rst, 1'b0);
        adv_to(448); chk("R6 reset copies high at 7T", card_rst, 1'b1);
        host_rst = 1'b0; #1;
        chk("R6 reset copies low", card_rst, 1'b0);
        end_session();

        // Delayed clock released by host (R8)
        begin_session(1'b1);
        adv_to(256); chk("R8 io at 4T", io_en, 1'b1);
                     chk("R8 clk held at 4T", clk_gate, 1'b0);
        adv_to(300); host_rst = 1'b0; #1;
        chk("R8 clk waits for edge", clk_gate, 1'b0);
        adv_to(301); chk("R8 clk after host fall", clk_gate, 1'b1);
        adv_to(350); host_rst = 1'b1;
        adv_to(360); chk("R9 clk stays on", clk_gate, 1'b1);
        adv_to(448); chk("R6 reset copy in delayed mode", card_rst, 1'b1);
        end_session();

        // Delayed clock forced at 7T (R9)
        begin_session(1'b1);
        adv_to(447); chk("R9 clk off before 7T", clk_gate, 1'b0);
        adv_to(448); chk("R9 clk forced at 7T", clk_gate, 1'b1);
        adv_to(460); host_rst = 1'b0;
        adv_to(470); chk("R9 clk unaffected by host", clk_gate, 1'b1);
                     chk("R6 reset follows host low", card_rst, 1'b0);
        end_session();

        // Card removal and restart from zero (R10)
        begin_session(1'b0);
        adv_to(100); chk("R10 ramp before removal", ramp_done, 1'b1);
        card_present = 1'b0; supply_ready = 1'b0; #1;
        all_low("R10 card removal");
        @(posedge clk); #(Q);
        begin_session(1'b0);
        adv_to(95);  chk("R10 restart counts from zero", ramp_done, 1'b0);
        adv_to(96);  chk("R10 restart ramp point", ramp_done, 1'b1);
        end_session();

        // Half-rate ticks (R11)
        tick_half = 1'b1;
        begin_session(1'b0);
        adv_to(100); chk("R11 ramp late at half rate", ramp_done, 1'b0);
        adv_to(190); chk("R11 ramp before doubled point", ramp_done, 1'b0);
        adv_to(194); chk("R11 ramp after doubled point", ramp_done, 1'b1);
        end_session();
        tick_half = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule